// File: doc/BRIEF.md
# Host Mailbox Control Sequencer

This block sits between a host processor and a sample-capture engine. The two sides share a small control memory, 256 words of 32 bits. The host writes trigger settings into fixed words, then raises a ready word. The sequencer fetches those settings one word at a time and holds them on registered outputs for the capture engine. If the host asked for it, the sequencer also starts a capture with a one-cycle arm pulse.

When the capture engine reports that a capture is complete, the sequencer does two things. It first writes the trigger address into the mailbox, and only then raises the done word. It then keeps reading the done word until the host clears it, and passes that acknowledgement on as a one-cycle pulse. The host uses its own port into the same memory, which works like a plain synchronous RAM port.

Top module: `mbx_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `arm_pulse` and `ack_pulse` are low. `trig_count`, `trig_mask` and `trig_value` reset to zero.
- R2: When bit 0 of word 0 is set, the sequencer reads word 2 (count), word 254 (mask) and word 255 (value) and presents them on `trig_count`, `trig_mask` and `trig_value`.
- R3: After a fetch, the sequencer writes 0 into word 0, so the host reads the ready word back as 0. Any arm pulse comes only after that clearing write.
- R4: When bit 0 of word 1 was set during a fetch, `arm_pulse` is high for exactly one cycle after the fetch. When that bit was clear, no arm pulse is produced.
- R5: While armed, `cap_complete` high makes the sequencer write `cap_taddr`, zero-extended, into word 3. In the following cycle it writes 1 into word 250; word 250 is never written without word 3 being written the cycle before.
- R6: After raising done, the sequencer waits while word 250 is nonzero. Once the host writes it to 0, `ack_pulse` is high for exactly one cycle and the sequencer is disarmed.
- R7: A word 0 with bit 0 clear starts no fetch. Changes the host makes to words 2, 254 and 255 leave the outputs unchanged until the next fetch.
- R8: `cap_complete` has no effect while not armed: word 250 stays 0 and no `ack_pulse` occurs.
- R9: A host read returns the addressed word on `host_rdata` one clock after the address is presented. A host write is visible to a later host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW (8) | Host word address |
| host_wdata | input | DW (32) | Host write data |
| host_rdata | output | DW (32) | Host read data, one cycle after the address |
| cap_complete | input | 1 | Capture engine reports a finished capture |
| cap_taddr | input | TAW (10) | Sample-buffer address of the trigger |
| trig_count | output | DW (32) | Fetched trigger count |
| trig_mask | output | DW (32) | Fetched trigger mask |
| trig_value | output | DW (32) | Fetched trigger value |
| arm_pulse | output | 1 | One-cycle start of a capture |
| ack_pulse | output | 1 | One-cycle host acknowledgement of done |

## Verification
The bench builds the block with its defaults: 32-bit words, an 8-bit address and a 10-bit trigger address. With an 8-bit address the fixed mailbox words 250, 254 and 255 exist, and a 10-bit trigger address lets the all-ones value 0x3FF check that the trigger address is zero-extended into word 3. The stimulus rows run two armed capture rounds with an unarmed round between them. This shows that a completion report is ignored while not armed and that the armed state is cleared after each acknowledgement.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Fixed mailbox word indices (host software depends on these)
  localparam int unsigned IDX_RDY   = 0;
  localparam int unsigned IDX_ARM   = 1;
  localparam int unsigned IDX_CNT   = 2;
  localparam int unsigned IDX_TADDR = 3;
  localparam int unsigned IDX_DONE  = 250;
  localparam int unsigned IDX_MASK  = 254;
  localparam int unsigned IDX_VAL   = 255;

  localparam int unsigned NUM_FLD = 3;

  typedef enum logic [1:0] {
    FLD_CNT  = 2'd0,
    FLD_MASK = 2'd1,
    FLD_VAL  = 2'd2
  } fld_t;

  typedef enum logic [3:0] {
    S_RDY_A, S_RDY_D,
    S_CNT_A, S_CNT_D,
    S_MSK_A, S_MSK_D,
    S_VAL_A, S_VAL_D,
    S_ARM_A, S_ARM_D,
    S_CLR,
    S_TADDR, S_DONE,
    S_ACK_A, S_ACK_D
  } seq_state_t;
endpackage

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // Read-before-write on both ports; port B wins a same-address write clash
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/mbx_param_bank.sv
module mbx_param_bank #(
  parameter int unsigned DW = 32,
  parameter int unsigned NF = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NF-1:0]        ld,
  input  logic [DW-1:0]        din,
  output logic [NF-1:0][DW-1:0] q
);
  for (genvar g = 0; g < NF; g++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (ld[g]) q[g] <= din;
    end
  end
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
  import mbx_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 8,
  parameter int unsigned TAW = 10,
  parameter int unsigned NF  = NUM_FLD
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cap_complete,
  input  logic [TAW-1:0] cap_taddr,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [NF-1:0]  ld,
  output logic           arm_pulse,
  output logic           ack_pulse
);
  seq_state_t state, nxt;
  logic       arm_req;
  logic       armed;

  // Memory port drive, decoded from the current state
  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = '0;
    mem_addr  = AW'(IDX_RDY);
    unique case (state)
      S_RDY_A, S_RDY_D: mem_addr = AW'(IDX_RDY);
      S_CNT_A, S_CNT_D: mem_addr = AW'(IDX_CNT);
      S_MSK_A, S_MSK_D: mem_addr = AW'(IDX_MASK);
      S_VAL_A, S_VAL_D: mem_addr = AW'(IDX_VAL);
      S_ARM_A, S_ARM_D: mem_addr = AW'(IDX_ARM);
      S_CLR: begin
        mem_addr = AW'(IDX_RDY);
        mem_we   = 1'b1;
      end
      S_TADDR: begin
        mem_addr  = AW'(IDX_TADDR);
        mem_we    = 1'b1;
        mem_wdata = DW'(cap_taddr);
      end
      S_DONE: begin
        mem_addr  = AW'(IDX_DONE);
        mem_we    = 1'b1;
        mem_wdata = DW'(1);
      end
      S_ACK_A, S_ACK_D: mem_addr = AW'(IDX_DONE);
      default: mem_addr = AW'(IDX_RDY);
    endcase
  end

  // Parameter load strobes: read data is valid in each capture state
  always_comb begin
    ld = '0;
    if (state == S_CNT_D) ld[int'(FLD_CNT)]  = 1'b1;
    if (state == S_MSK_D) ld[int'(FLD_MASK)] = 1'b1;
    if (state == S_VAL_D) ld[int'(FLD_VAL)]  = 1'b1;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_RDY_A: nxt = S_RDY_D;
      S_RDY_D: begin
        if (armed && cap_complete) nxt = S_TADDR;
        else if (mem_rdata[0])     nxt = S_CNT_A;
        else                       nxt = S_RDY_A;
      end
      S_CNT_A: nxt = S_CNT_D;
      S_CNT_D: nxt = S_MSK_A;
      S_MSK_A: nxt = S_MSK_D;
      S_MSK_D: nxt = S_VAL_A;
      S_VAL_A: nxt = S_VAL_D;
      S_VAL_D: nxt = S_ARM_A;
      S_ARM_A: nxt = S_ARM_D;
      S_ARM_D: nxt = S_CLR;
      S_CLR:   nxt = S_RDY_A;
      S_TADDR: nxt = S_DONE;
      S_DONE:  nxt = S_ACK_A;
      S_ACK_A: nxt = S_ACK_D;
      S_ACK_D: nxt = (mem_rdata == '0) ? S_RDY_A : S_ACK_A;
      default: nxt = S_RDY_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_RDY_A;
      arm_req   <= 1'b0;
      armed     <= 1'b0;
      arm_pulse <= 1'b0;
      ack_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      arm_pulse <= 1'b0;
      ack_pulse <= 1'b0;
      if (state == S_ARM_D) arm_req <= mem_rdata[0];
      if (state == S_CLR && arm_req) begin
        arm_pulse <= 1'b1;
        armed     <= 1'b1;
      end
      if (state == S_ACK_D && mem_rdata == '0) begin
        ack_pulse <= 1'b1;
        armed     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 8,
  parameter int unsigned TAW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           cap_complete,
  input  logic [TAW-1:0] cap_taddr,
  output logic [DW-1:0]  trig_count,
  output logic [DW-1:0]  trig_mask,
  output logic [DW-1:0]  trig_value,
  output logic           arm_pulse,
  output logic           ack_pulse
);
  localparam int unsigned NF = NUM_FLD;

  initial begin
    if (AW < 8)   $error("mbx_seq: AW must reach word 255");
    if (TAW > DW) $error("mbx_seq: trigger address wider than a word");
  end

  logic                  seq_we;
  logic [AW-1:0]         seq_addr;
  logic [DW-1:0]         seq_wdata;
  logic [DW-1:0]         seq_rdata;
  logic [NF-1:0]         ld;
  logic [NF-1:0][DW-1:0] pq;

  mbx_dpram #(.DW(DW), .AW(AW)) u_ram (
    .clk    (clk),
    .a_we   (seq_we),
    .a_addr (seq_addr),
    .a_wdata(seq_wdata),
    .a_rdata(seq_rdata),
    .b_we   (host_we),
    .b_addr (host_addr),
    .b_wdata(host_wdata),
    .b_rdata(host_rdata)
  );

  mbx_fsm #(.DW(DW), .AW(AW), .TAW(TAW), .NF(NF)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cap_complete(cap_complete),
    .cap_taddr   (cap_taddr),
    .mem_we      (seq_we),
    .mem_addr    (seq_addr),
    .mem_wdata   (seq_wdata),
    .mem_rdata   (seq_rdata),
    .ld          (ld),
    .arm_pulse   (arm_pulse),
    .ack_pulse   (ack_pulse)
  );

  mbx_param_bank #(.DW(DW), .NF(NF)) u_params (
    .clk(clk),
    .rst(rst),
    .ld (ld),
    .din(seq_rdata),
    .q  (pq)
  );

  assign trig_count = pq[int'(FLD_CNT)];
  assign trig_mask  = pq[int'(FLD_MASK)];
  assign trig_value = pq[int'(FLD_VAL)];
endmodule

// File: rtl/mbx_seq_chk.sv
module mbx_seq_chk
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          arm_pulse,
  input logic          ack_pulse,
  input logic          seq_we,
  input logic [AW-1:0] seq_addr,
  input logic [DW-1:0] seq_wdata
);
  // R1: pulses are quiet right after a reset cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!arm_pulse && !ack_pulse));

  // R4: arm lasts one cycle
  a_r4_arm_single: assert property (@(posedge clk) disable iff (rst)
    arm_pulse |=> !arm_pulse);

  // R6: acknowledgement lasts one cycle
  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |=> !ack_pulse);

  // R3: arm follows the write that clears the ready word
  a_r3_arm_after_clear: assert property (@(posedge clk) disable iff (rst)
    arm_pulse |-> $past(seq_we && seq_addr == AW'(IDX_RDY) && seq_wdata == '0));

  // R5: done is raised only right after the trigger address was stored
  a_r5_taddr_before_done: assert property (@(posedge clk) disable iff (rst)
    (seq_we && seq_addr == AW'(IDX_DONE)) |-> $past(seq_we && seq_addr == AW'(IDX_TADDR)));
endmodule

bind mbx_seq mbx_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .arm_pulse(arm_pulse),
  .ack_pulse(ack_pulse),
  .seq_we   (seq_we),
  .seq_addr (seq_addr),
  .seq_wdata(seq_wdata)
);

// File: tb/mbx_seq_bench.sv
module mbx_seq_bench;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int TAW = 10;
  localparam int WATCHDOG = 100000;

  typedef struct packed {
    logic [31:0] cnt;
    logic [31:0] msk;
    logic [31:0] val;
    logic        arm;
    logic [9:0]  ta;
  } row_t;

  localparam int NROW = 3;
  localparam row_t TBL [NROW] = '{
    '{cnt: 32'd499,  msk: 32'h0000_FFFF, val: 32'h0000_1000, arm: 1'b1, ta: 10'h1F3},
    '{cnt: 32'd7,    msk: 32'hFFFF_FFFF, val: 32'hDEAD_BEEF, arm: 1'b0, ta: 10'h02A},
    '{cnt: 32'd1023, msk: 32'h0000_00F0, val: 32'h0000_0030, arm: 1'b1, ta: 10'h3FF}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           host_we = 1'b0;
  logic [AW-1:0]  host_addr = '0;
  logic [DW-1:0]  host_wdata = '0;
  logic [DW-1:0]  host_rdata;
  logic           cap_complete = 1'b0;
  logic [TAW-1:0] cap_taddr = '0;
  logic [DW-1:0]  trig_count, trig_mask, trig_value;
  logic           arm_pulse, ack_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int arm_cnt = 0;
  int ack_cnt = 0;

  always #10 clk = ~clk;

  mbx_seq #(.DW(DW), .AW(AW), .TAW(TAW)) u_mbx_seq (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cap_complete(cap_complete), .cap_taddr(cap_taddr),
    .trig_count(trig_count), .trig_mask(trig_mask), .trig_value(trig_value),
    .arm_pulse(arm_pulse), .ack_pulse(ack_pulse)
  );

  always @(negedge clk) begin
    if (!rst && arm_pulse) arm_cnt <= arm_cnt + 1;
    if (!rst && ack_pulse) ack_cnt <= ack_cnt + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_addr  = AW'(a);
    host_wdata = d;
    host_we    = 1'b1;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic host_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = AW'(a);
    host_we   = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_word(input int a, input logic [31:0] v, input int limit, output logic ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      host_rd(a, d);
      if (d == v) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic ok;
    int a0, k0;

    // R1: reset values
    idle(3);
    chk("R1 arm_pulse in reset", {31'b0, arm_pulse}, 32'd0);
    chk("R1 ack_pulse in reset", {31'b0, ack_pulse}, 32'd0);
    chk("R1 trig_count reset", trig_count, 32'd0);
    chk("R1 trig_mask|value reset", trig_mask | trig_value, 32'd0);
    rst = 1'b0;
    idle(2);

    // R9: host write then read, one cycle read latency
    host_wr(100, 32'hA5A5_0F0F);
    @(negedge clk);
    host_addr = AW'(100);
    @(negedge clk);
    chk("R9 host read after one cycle", host_rdata, 32'hA5A5_0F0F);

    for (int r = 0; r < NROW; r++) begin
      host_wr(2,   TBL[r].cnt);
      host_wr(254, TBL[r].msk);
      host_wr(255, TBL[r].val);
      host_wr(1,   {31'b0, TBL[r].arm});
      host_wr(3,   32'd0);
      a0 = arm_cnt;
      k0 = ack_cnt;
      host_wr(0,   32'd1);
      wait_word(0, 32'd0, 200, ok);
      chk("R3 ready word cleared after fetch", {31'b0, ok}, 32'd1);
      idle(2);
      chk("R2 trig_count", trig_count, TBL[r].cnt);
      chk("R2 trig_mask",  trig_mask,  TBL[r].msk);
      chk("R2 trig_value", trig_value, TBL[r].val);
      chk("R4 arm pulse count", arm_cnt - a0, TBL[r].arm ? 32'd1 : 32'd0);

      cap_taddr    = TBL[r].ta;
      cap_complete = 1'b1;
      if (TBL[r].arm) begin
        wait_word(250, 32'd1, 200, ok);
        chk("R5 done raised", {31'b0, ok}, 32'd1);
        host_rd(3, d);
        chk("R5 trigger address word", d, {22'b0, TBL[r].ta});
        cap_complete = 1'b0;
        idle(5);
        chk("R6 no ack while done set", ack_cnt - k0, 32'd0);
        host_wr(250, 32'd0);
        idle(8);
        chk("R6 single ack after clear", ack_cnt - k0, 32'd1);
      end else begin
        idle(40);
        host_rd(250, d);
        chk("R8 done untouched when unarmed", d, 32'd0);
        host_rd(3, d);
        chk("R8 trigger word untouched", d, 32'd0);
        chk("R8 no ack when unarmed", ack_cnt - k0, 32'd0);
        cap_complete = 1'b0;
      end
    end

    // R7: ready word with bit 0 clear, parameters changed in memory
    host_wr(254, 32'h1234_5678);
    host_wr(2,   32'd55);
    host_wr(0,   32'd2);
    idle(30);
    chk("R7 mask unchanged", trig_mask, TBL[NROW-1].msk);
    chk("R7 count unchanged", trig_count, TBL[NROW-1].cnt);
    host_rd(0, d);
    chk("R7 ready word left as written", d, 32'd2);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    chk("R1 params cleared by reset", trig_count | trig_mask | trig_value, 32'd0);
    rst = 1'b0;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule